// File: doc/BRIEF.md
# Four-Channel DMA Control Register Bank

This block holds the controller-wide registers of a four-channel DMA engine: the command byte, the per-channel mask bits, the status byte and one mode byte per channel. It also holds the byte-pointer flip-flop used by the neighbouring address/count file. A byte-wide register bus reaches it at offsets 8 to 15 of a 16-offset window. Writes there update the registers, and reads return status or mask. Peripherals raise and drop their hardware requests on per-channel pulse inputs. The transfer engine reports terminal count on its own pulse input.

The status byte carries terminal-count flags in bits 3:0 and request flags in bits 7:4, one bit per channel in channel order. Reading status hands back the byte as it stood and wipes the terminal-count half. Command writes that ask for a feature the engine does not support are dropped whole. A master-clear write and the hardware reset both leave the bank in the same idle state, except that the hardware reset also zeroes the mode bytes.

Top module: `dmac_ctl_regs`

## Requirements
- R1: After reset, mask is 4'hF, status 8'h00, command 8'h00, the flip-flop 0 and every mode byte 8'h00.
- R2: A write at offset 8 loads the command only if the data has no bit set outside bit 2 (mask 8'hFB); otherwise the command keeps its value.
- R3: A write at offset 9 takes the channel from data[1:0]; data[2] becomes status bit 4+channel, and status bit channel is cleared.
- R4: A write at offset 10 sets mask bit data[1:0] to data[2].
- R5: A write at offset 11 stores the whole data byte as the mode byte of channel data[1:0], found at modes[8*ch+7:8*ch]; other channels keep theirs.
- R6: A pulse on ptr_toggle inverts the flip-flop; a write at offset 12 clears it.
- R7: A write at offset 13 clears the flip-flop, status and command and sets all mask bits; the mode bytes are kept.
- R8: A write at offset 14 clears all mask bits; a write at offset 15 loads the mask from data[3:0].
- R9: A read at offset 8 puts status on rdata in the next cycle and clears status bits 3:0. A read at offset 15 returns {4'h0, mask}, and any other offset reads 8'h00.
- R10: dreq_on[ch] sets status bit 4+ch, and dreq_off[ch] clears it; if both pulse together, the bit ends set.
- R11: If a write at offset 9 and an external request pulse hit the same channel in one cycle, the write decides the request bit.
- R12: tc_hit[ch] sets status bit ch, and it is kept even when a status read clears the low half in the same cycle.
- R13: Writes at offsets 0 to 7 change no register of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 4 | register offset in the 16-offset window |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, valid the cycle after rd_en |
| dreq_on | input | 4 | per-channel request assert pulse |
| dreq_off | input | 4 | per-channel request release pulse |
| tc_hit | input | 4 | per-channel terminal-count pulse |
| ptr_toggle | input | 1 | flip-flop toggle from the address/count file |
| command | output | 8 | command register |
| mask | output | 4 | channel mask bits |
| status | output | 8 | status: requests 7:4, terminal count 3:0 |
| modes | output | 32 | mode bytes, channel 0 in bits 7:0 |
| ptr_ff | output | 1 | byte-pointer flip-flop |

## Verification
The properties assume the bus never raises wr_en and rd_en in the same cycle. They also assume that inputs change only between clock edges. The stimulus drives every input on the falling edge and issues at most one bus operation per cycle. Request, release and terminal-count pulses are placed alongside bus writes and reads on purpose, so that the same-cycle priorities of R10, R11 and R12 are exercised.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
    localparam int BYTE_W = 8;

    // decoded offset within the control group (offset 8 + value); order is decoded
    typedef enum logic [2:0] {
        OFS_CMD     = 3'd0,
        OFS_REQ     = 3'd1,
        OFS_SMASK   = 3'd2,
        OFS_MODE    = 3'd3,
        OFS_PTRCLR  = 3'd4,
        OFS_MCLR    = 3'd5,
        OFS_UNMASK  = 3'd6,
        OFS_MASKALL = 3'd7
    } ctl_ofs_e;

    typedef struct packed {
        logic cmd;
        logic req;
        logic smask;
        logic mode;
        logic ptrclr;
        logic mclr;
        logic unmask;
        logic maskall;
        logic rd_stat;
        logic rd_mask;
    } ctl_strobe_t;

    // command bits that request features the engine lacks
    localparam logic [BYTE_W-1:0] CMD_UNSUPPORTED = 8'hFB;
endpackage

// File: rtl/dmac_ctl_decode.sv
module dmac_ctl_decode
    import dmac_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output ctl_strobe_t       strb
);
    localparam int GRP_BIT = ADDR_W - 1;

    ctl_ofs_e ofs;

    always_comb begin
        ofs  = ctl_ofs_e'(addr[2:0]);
        strb = '0;
        if (wr_en && addr[GRP_BIT]) begin
            case (ofs)
                OFS_CMD:     strb.cmd     = 1'b1;
                OFS_REQ:     strb.req     = 1'b1;
                OFS_SMASK:   strb.smask   = 1'b1;
                OFS_MODE:    strb.mode    = 1'b1;
                OFS_PTRCLR:  strb.ptrclr  = 1'b1;
                OFS_MCLR:    strb.mclr    = 1'b1;
                OFS_UNMASK:  strb.unmask  = 1'b1;
                OFS_MASKALL: strb.maskall = 1'b1;
                default:     strb         = '0;
            endcase
        end
        if (rd_en && addr[GRP_BIT]) begin
            strb.rd_stat = (ofs == OFS_CMD);
            strb.rd_mask = (ofs == OFS_MASKALL);
        end
    end

    // R13: at most one register action per cycle
    a_r13_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en) |-> $onehot0(strb));
endmodule

// File: rtl/dmac_mask_reg.sv
module dmac_mask_reg
    import dmac_ctl_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_strobe_t       strb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [N_CH-1:0]   mask_q
);
    localparam int CH_W    = $clog2(N_CH);
    localparam int SET_BIT = CH_W;

    logic [N_CH-1:0] mask_d;
    logic [CH_W-1:0] ch;

    always_comb begin
        ch     = wdata[CH_W-1:0];
        mask_d = mask_q;
        if (strb.smask)   mask_d[ch] = wdata[SET_BIT];
        if (strb.unmask)  mask_d     = '0;
        if (strb.maskall) mask_d     = wdata[N_CH-1:0];
        if (strb.mclr)    mask_d     = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    a_r7_mclr_masks_all: assert property (@(posedge clk) disable iff (!rst_n)
        strb.mclr |=> (mask_q == '1));
    a_r8_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
        strb.unmask |=> (mask_q == '0));
    a_r8_load_all: assert property (@(posedge clk) disable iff (!rst_n)
        strb.maskall |=> (mask_q == $past(wdata[N_CH-1:0])));
    a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
        strb.smask |=> (mask_q[$past(ch)] == $past(wdata[SET_BIT])));
endmodule

// File: rtl/dmac_status_reg.sv
module dmac_status_reg
    import dmac_ctl_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_strobe_t       strb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [N_CH-1:0]   dreq_on,
    input  logic [N_CH-1:0]   dreq_off,
    input  logic [N_CH-1:0]   tc_hit,
    output logic [2*N_CH-1:0] status_q
);
    localparam int CH_W    = $clog2(N_CH);
    localparam int SET_BIT = CH_W;

    typedef struct packed {
        logic [N_CH-1:0] req;
        logic [N_CH-1:0] tc;
    } stat_t;

    stat_t           s_q, s_d;
    logic [CH_W-1:0] ch;

    always_comb begin
        ch  = wdata[CH_W-1:0];
        s_d = s_q;
        // external request lines: assert beats release
        s_d.req = (s_q.req & ~dreq_off) | dreq_on;
        // read clears terminal count, a fresh terminal count survives
        if (strb.rd_stat) s_d.tc = '0;
        s_d.tc = s_d.tc | tc_hit;
        // software request write overrides the external lines
        if (strb.req) begin
            s_d.req[ch] = wdata[SET_BIT];
            s_d.tc[ch]  = 1'b0;
        end
        if (strb.mclr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_q = s_q;

    a_r9_read_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.rd_stat && tc_hit == '0) |=> (status_q[N_CH-1:0] == '0));
    a_r7_mclr_status: assert property (@(posedge clk) disable iff (!rst_n)
        strb.mclr |=> (status_q == '0));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        a_r10_req_on: assert property (@(posedge clk) disable iff (!rst_n)
            (dreq_on[i] && !(strb.req && ch == CH_W'(i)) && !strb.mclr)
            |=> status_q[N_CH+i]);
        a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (strb.req && ch == CH_W'(i))
            |=> (status_q[N_CH+i] == $past(wdata[SET_BIT])) && !status_q[i]);
        a_r12_tc_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (tc_hit[i] && !(strb.req && ch == CH_W'(i)) && !strb.mclr)
            |=> status_q[i]);
    end
endmodule

// File: rtl/dmac_mode_file.sv
module dmac_mode_file
    import dmac_ctl_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  ctl_strobe_t              strb,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [N_CH*BYTE_W-1:0]   modes_q
);
    localparam int CH_W = $clog2(N_CH);

    logic [CH_W-1:0] ch;
    assign ch = wdata[CH_W-1:0];

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [BYTE_W-1:0] mode_d, mode_q;
        logic              hit;

        always_comb begin
            hit    = strb.mode && (ch == CH_W'(i));
            mode_d = hit ? wdata : mode_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mode_q <= '0;
            else        mode_q <= mode_d;
        end

        assign modes_q[i*BYTE_W +: BYTE_W] = mode_q;

        a_r5_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
            (strb.mode && ch == CH_W'(i)) |=> (modes_q[i*BYTE_W +: BYTE_W] == $past(wdata)));
        a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(strb.mode && ch == CH_W'(i)) |=> $stable(modes_q[i*BYTE_W +: BYTE_W]));
    end
endmodule

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
    import dmac_ctl_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    input  logic [N_CH-1:0]        dreq_on,
    input  logic [N_CH-1:0]        dreq_off,
    input  logic [N_CH-1:0]        tc_hit,
    input  logic                   ptr_toggle,
    output logic [7:0]             command,
    output logic [N_CH-1:0]        mask,
    output logic [2*N_CH-1:0]      status,
    output logic [N_CH*8-1:0]      modes,
    output logic                   ptr_ff
);
    localparam int DW = BYTE_W;

    typedef struct packed {
        logic [DW-1:0] cmd;
        logic          ff;
        logic [DW-1:0] rd;
    } top_t;

    ctl_strobe_t        strb;
    logic [N_CH-1:0]    mask_w;
    logic [2*N_CH-1:0]  status_w;
    top_t               t_q, t_d;

    dmac_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .strb(strb)
    );

    dmac_mask_reg #(.N_CH(N_CH)) u_mask (
        .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(wdata), .mask_q(mask_w)
    );

    dmac_status_reg #(.N_CH(N_CH)) u_stat (
        .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(wdata),
        .dreq_on(dreq_on), .dreq_off(dreq_off), .tc_hit(tc_hit),
        .status_q(status_w)
    );

    dmac_mode_file #(.N_CH(N_CH)) u_mode (
        .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(wdata), .modes_q(modes)
    );

    always_comb begin
        t_d = t_q;
        if (strb.cmd && ((wdata & CMD_UNSUPPORTED) == '0)) t_d.cmd = wdata;
        if (ptr_toggle)  t_d.ff = ~t_q.ff;
        if (strb.ptrclr) t_d.ff = 1'b0;
        if (strb.mclr) begin
            t_d.ff  = 1'b0;
            t_d.cmd = '0;
        end
        if (rd_en) begin
            if (strb.rd_stat)      t_d.rd = DW'(status_w);
            else if (strb.rd_mask) t_d.rd = DW'(mask_w);
            else                   t_d.rd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign command = t_q.cmd;
    assign ptr_ff  = t_q.ff;
    assign rdata   = t_q.rd;
    assign mask    = mask_w;
    assign status  = status_w;

    a_r9_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.cmd && (wdata & CMD_UNSUPPORTED) != '0) |=> $stable(command));
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.cmd && (wdata & CMD_UNSUPPORTED) == '0) |=> (command == $past(wdata)));
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_toggle && !strb.ptrclr && !strb.mclr) |=> (ptr_ff != $past(ptr_ff)));
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.ptrclr || strb.mclr) |=> !ptr_ff);
    a_r9_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        strb.rd_stat |=> (rdata == DW'($past(status_w))));
    a_r13_low_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[ADDR_W-1] && !ptr_toggle && dreq_on == '0 && dreq_off == '0 && tc_hit == '0)
        |=> $stable(command) && $stable(mask) && $stable(status) && $stable(ptr_ff));
endmodule

// File: tb/sim_dmac_ctl_regs.sv
module sim_dmac_ctl_regs;
    typedef enum int {E_CMD, E_MASK, E_STAT, E_FF, E_MODE, E_RD} ek_e;
    typedef struct {
        ek_e         kind;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, ptr_toggle = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  dreq_on = '0, dreq_off = '0, tc_hit = '0;
    logic [7:0]  rdata, command, status;
    logic [3:0]  mask;
    logic [31:0] modes;
    logic        ptr_ff;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t exp_q[$];
    event chk_ev;

    always #10 clk = ~clk;

    dmac_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dreq_on(dreq_on), .dreq_off(dreq_off),
        .tc_hit(tc_hit), .ptr_toggle(ptr_toggle), .command(command), .mask(mask),
        .status(status), .modes(modes), .ptr_ff(ptr_ff)
    );

    task automatic expect_v(input ek_e k, input logic [31:0] v, input string tag);
        exp_t it;
        it.kind = k; it.val = v; it.tag = tag;
        exp_q.push_back(it);
        -> chk_ev;
    endtask

    // one bus cycle, inputs driven on the falling edge, released one cycle later
    task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                       input logic [7:0] d, input logic [3:0] on, input logic [3:0] off,
                       input logic [3:0] tc, input logic tg);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        dreq_on = on; dreq_off = off; tc_hit = tc; ptr_toggle = tg;
        @(negedge clk);
        wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        dreq_on = '0; dreq_off = '0; tc_hit = '0; ptr_toggle = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1, 0, a, d, 4'h0, 4'h0, 4'h0, 0);
    endtask

    task automatic rd(input logic [3:0] a);
        cyc(0, 1, a, 8'h00, 4'h0, 4'h0, 4'h0, 0);
    endtask

    // monitor: pops expectations and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t        it;
                logic [31:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    E_CMD:  act = 32'(command);
                    E_MASK: act = 32'(mask);
                    E_STAT: act = 32'(status);
                    E_FF:   act = 32'(ptr_ff);
                    E_MODE: act = modes;
                    default: act = 32'(rdata);
                endcase
                n_chk++;
                if (act !== it.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_v(E_MASK, 32'hF, "R1 mask");
        expect_v(E_STAT, 32'h00, "R1 status");
        expect_v(E_CMD, 32'h00, "R1 command");
        expect_v(E_FF, 32'h0, "R1 flip-flop");
        expect_v(E_MODE, 32'h0, "R1 modes");

        wr(4'd8, 8'h04); expect_v(E_CMD, 32'h04, "R2 accept 04");
        wr(4'd8, 8'h05); expect_v(E_CMD, 32'h04, "R2 reject 05");
        wr(4'd8, 8'h80); expect_v(E_CMD, 32'h04, "R2 reject 80");
        wr(4'd8, 8'h00); expect_v(E_CMD, 32'h00, "R2 accept zero");

        wr(4'd10, 8'h01); expect_v(E_MASK, 32'hD, "R4 clear bit1");
        wr(4'd10, 8'h05); expect_v(E_MASK, 32'hF, "R4 set bit1");

        wr(4'd14, 8'hFF); expect_v(E_MASK, 32'h0, "R8 clear all");
        wr(4'd15, 8'hA5); expect_v(E_MASK, 32'h5, "R8 load all");

        wr(4'd11, 8'h96); expect_v(E_MODE, 32'h0096_0000, "R5 mode ch2");
        wr(4'd11, 8'h47); expect_v(E_MODE, 32'h4796_0000, "R5 mode ch3");

        cyc(0, 0, 4'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1); expect_v(E_FF, 32'h1, "R6 toggle");
        wr(4'd12, 8'h00); expect_v(E_FF, 32'h0, "R6 clear");

        cyc(0, 0, 4'd0, 8'h00, 4'h2, 4'h0, 4'h0, 0); expect_v(E_STAT, 32'h20, "R10 assert ch1");
        cyc(0, 0, 4'd0, 8'h00, 4'h0, 4'h2, 4'h0, 0); expect_v(E_STAT, 32'h00, "R10 release ch1");
        cyc(0, 0, 4'd0, 8'h00, 4'h8, 4'h8, 4'h0, 0); expect_v(E_STAT, 32'h80, "R10 both ch3");
        cyc(0, 0, 4'd0, 8'h00, 4'h0, 4'h8, 4'h0, 0); expect_v(E_STAT, 32'h00, "R10 release ch3");

        cyc(0, 0, 4'd0, 8'h00, 4'h0, 4'h0, 4'h1, 0); expect_v(E_STAT, 32'h01, "R12 tc ch0");
        wr(4'd9, 8'h05); expect_v(E_STAT, 32'h21, "R3 set req ch1");
        wr(4'd9, 8'h00); expect_v(E_STAT, 32'h20, "R3 clear ch0 tc");

        cyc(0, 0, 4'd0, 8'h00, 4'h0, 4'h0, 4'h3, 0); expect_v(E_STAT, 32'h23, "R12 tc ch0 ch1");
        rd(4'd8);
        expect_v(E_RD, 32'h23, "R9 status read");
        expect_v(E_STAT, 32'h20, "R9 read clears tc");
        rd(4'd15); expect_v(E_RD, 32'h05, "R9 mask read");
        rd(4'd3);  expect_v(E_RD, 32'h00, "R9 low offset read");
        rd(4'd9);  expect_v(E_RD, 32'h00, "R9 other offset read");

        cyc(0, 1, 4'd8, 8'h00, 4'h0, 4'h0, 4'h4, 0);
        expect_v(E_RD, 32'h20, "R12 read value");
        expect_v(E_STAT, 32'h24, "R12 tc survives read");

        cyc(1, 0, 4'd9, 8'h01, 4'h2, 4'h0, 4'h0, 0); expect_v(E_STAT, 32'h04, "R11 write beats assert");
        cyc(1, 0, 4'd9, 8'h06, 4'h0, 4'h4, 4'h0, 0); expect_v(E_STAT, 32'h40, "R11 write beats release");

        wr(4'd3, 8'hFF);
        expect_v(E_MASK, 32'h5, "R13 mask kept");
        expect_v(E_CMD, 32'h00, "R13 command kept");
        expect_v(E_STAT, 32'h40, "R13 status kept");
        expect_v(E_MODE, 32'h4796_0000, "R13 modes kept");

        wr(4'd8, 8'h04);
        wr(4'd14, 8'h00);
        cyc(0, 0, 4'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1);
        expect_v(E_FF, 32'h1, "R6 toggle before clear");
        wr(4'd13, 8'h00);
        expect_v(E_MASK, 32'hF, "R7 mask set");
        expect_v(E_STAT, 32'h00, "R7 status zero");
        expect_v(E_CMD, 32'h00, "R7 command zero");
        expect_v(E_FF, 32'h0, "R7 flip-flop zero");
        expect_v(E_MODE, 32'h4796_0000, "R7 modes kept");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule